// File: doc/BRIEF.md
# Data Cache Line Policy Controller

This block is the decision core of a small direct-mapped data cache. For each processor access it compares the address with the stored tag and line state. It then chooses one of three outcomes: the access completes in the cache, the controller fetches or writes back whole lines, or a single transfer goes straight to memory. The choice depends on the page caching mode, the access class and a no-allocate control bit. The block also watches snooped bus writes and keeps line states coherent with them. The data array and the bus timing are outside the block. The controller only issues bus commands and waits for a done strobe for each one.

A processor request is offered with a valid/ready handshake, and only one request is in flight at a time. Every request produces exactly one response pulse, which reports whether the access hit a line. The response comes one cycle after acceptance when no bus transfer is needed. Otherwise it comes one cycle after the last bus command completes. Snoops arrive as line addresses and are serviced only while the controller is idle. When they are serviced they take precedence over a waiting processor request.

Top module: `dcache_policy_ctrl`

## Requirements
- R1: A read miss of class normal (reqClass 0) to a writethrough (reqMode 0) or copyback (reqMode 1) page with noAlloc low issues a line fill (busCmd 2) to the line-aligned address. The line then becomes valid, so a repeated read hits with no bus command.
- R2: With noAlloc high, a cachable read miss issues a single read (busCmd 0) and a cachable write miss issues a single write (busCmd 1). No line is loaded, so the next allocating access to that line misses.
- R3: A normal write miss to a copyback page issues a line fill and leaves the line dirty. A later read of it hits, and evicting it causes a writeback.
- R4: A write miss to a writethrough page issues one single write to the full address and allocates nothing.
- R5: A copyback write hit marks the line dirty with no bus command. A writethrough write hit issues a single write and reports a hit.
- R6: A fill that replaces a dirty line first issues a line writeback (busCmd 3) to the victim's line address. The fill follows only after the writeback's busDone.
- R7: Exception-class accesses (reqClass 1) never allocate on a miss and use single transfers instead. On a hit they follow the page-mode rules, so a copyback write hit dirties the line.
- R8: Block-move accesses (reqClass 2) never allocate. A read hit completes from the cache. A write hit reports a hit, issues a single write and invalidates the line.
- R9: Table-walk accesses (reqClass 3) always use single transfers, even when the line is present, and change no line state.
- R10: Locked accesses (reqClass 4) and any access to a cache-inhibited page (reqMode 2 or 3) use single transfers and change no line state, whatever page mode is supplied.
- R11: A snoop changes state only when snpEnable is high. A snooped write that hits a valid line invalidates it. Snooped reads and snooped misses change nothing.
- R12: A snooped write that hits a dirty line raises snpConflict for exactly one cycle, in the cycle after the snoop, and leaves the line unchanged.
- R13: reqReady is high only while idle with no enabled snoop pending. After reset reqReady and snpReady are high and busValid, respValid and snpConflict are low. respValid pulses once per request.
- R14: While busValid is high and busDone is low, busCmd and busAddr stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request offered |
| reqReady | output | 1 | Processor request accepted this cycle if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqMode | input | 2 | Page mode: 0 writethrough, 1 copyback, 2/3 inhibited precise |
| reqClass | input | 3 | 0 normal, 1 exception stack/vector, 2 block move, 3 table walk, 4 locked |
| noAlloc | input | 1 | Suppress line allocation on misses |
| respValid | output | 1 | One-cycle completion pulse |
| respHit | output | 1 | Request hit a present line |
| snpValid | input | 1 | Snooped bus transfer present |
| snpReady | output | 1 | Snoop is serviced this cycle if valid |
| snpWrite | input | 1 | Snooped transfer is a write |
| snpEnable | input | 1 | Snooped transfer is marked snoopable |
| snpLine | input | ADDR_W-log2(LINE_BYTES) | Line address of the snooped transfer |
| snpConflict | output | 1 | Snooped write hit a dirty line |
| busValid | output | 1 | Bus command pending |
| busCmd | output | 2 | 0 single read, 1 single write, 2 line fill, 3 line writeback |
| busAddr | output | ADDR_W | Address of the pending command |
| busDone | input | 1 | Pending command finished |

## Verification
One ordered stream of accesses runs through the block, so each result depends on the state left by earlier accesses. A bypass or no-allocate access is followed by an allocating access to the same line, which shows whether a line was loaded. An eviction then shows whether the dirty bit was set. Every access class meets every relevant line state (absent, valid, dirty) under both writethrough and copyback pages. Snoops are tried enabled and disabled, as reads and writes, and against valid, dirty and absent lines, and each case is followed by a probing read. A stalled busDone and a snoop that collides with a request cover the sequencing rules.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_VALID = 2'd1,
    LS_DIRTY = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    BC_READ  = 2'd0,
    BC_WRITE = 2'd1,
    BC_FILL  = 2'd2,
    BC_WBACK = 2'd3
  } busCmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WBACK  = 2'd1,
    ST_FILL   = 2'd2,
    ST_SINGLE = 2'd3
  } ctlState_e;

  typedef enum logic [1:0] {
    AS_FULL   = 2'd0,
    AS_LINE   = 2'd1,
    AS_VICTIM = 2'd2
  } addrSel_e;

  localparam logic [1:0] PM_WT = 2'd0;
  localparam logic [1:0] PM_CB = 2'd1;

  localparam logic [2:0] AC_NORMAL = 3'd0;
  localparam logic [2:0] AC_EXCEPT = 3'd1;
  localparam logic [2:0] AC_BLOCK  = 3'd2;
  localparam logic [2:0] AC_WALK   = 3'd3;
  localparam logic [2:0] AC_LOCKED = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic     latch;      // capture request address and victim tag
    logic     hitDirty;   // mark looked-up line dirty
    logic     hitInv;     // invalidate looked-up line
    logic     victimInv;  // victim written back
    logic     fillWrite;  // install latched line
    logic     fillDirty;  // installed line starts dirty
    logic     snpInv;     // invalidate snooped line
    addrSel_e addrSel;    // bus address source
  } dpCtrl_t;

endpackage

// File: rtl/dcp_datapath.sv
module dcp_datapath
  import dcp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpCtrl_t                            ctrl,
  input  logic [ADDR_W-1:0]                  reqAddr,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] snpLine,
  output lineState_e                         reqState,
  output logic                               reqMatch,
  output lineState_e                         snpState,
  output logic                               snpMatch,
  output logic [ADDR_W-1:0]                  busAddr
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [TAG_W-1:0] tagArr [NUM_LINES];
  lineState_e       stateArr [NUM_LINES];

  logic [ADDR_W-1:0] addrQ;
  logic [TAG_W-1:0]  victimTagQ;

  logic [IDX_W-1:0] reqIdx, snpIdx, qIdx;
  logic [TAG_W-1:0] reqTag, snpTag, qTag;

  assign reqIdx = reqAddr[OFF_W +: IDX_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign snpIdx = snpLine[IDX_W-1:0];
  assign snpTag = snpLine[ADDR_W-OFF_W-1 -: TAG_W];
  assign qIdx   = addrQ[OFF_W +: IDX_W];
  assign qTag   = addrQ[ADDR_W-1 -: TAG_W];

  assign reqState = stateArr[reqIdx];
  assign reqMatch = (tagArr[reqIdx] == reqTag);
  assign snpState = stateArr[snpIdx];
  assign snpMatch = (tagArr[snpIdx] == snpTag);

  // line state array, later strobes win
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) stateArr[i] <= LS_INV;
    end else begin
      if (ctrl.hitDirty)  stateArr[reqIdx] <= LS_DIRTY;
      if (ctrl.hitInv)    stateArr[reqIdx] <= LS_INV;
      if (ctrl.victimInv) stateArr[qIdx]   <= LS_INV;
      if (ctrl.fillWrite) stateArr[qIdx]   <= ctrl.fillDirty ? LS_DIRTY : LS_VALID;
      if (ctrl.snpInv)    stateArr[snpIdx] <= LS_INV;
    end
  end

  // tags and request latch need no reset: guarded by state
  always_ff @(posedge clk) begin
    if (ctrl.fillWrite) tagArr[qIdx] <= qTag;
    if (ctrl.latch) begin
      addrQ      <= reqAddr;
      victimTagQ <= tagArr[reqIdx];
    end
  end

  always_comb begin
    unique case (ctrl.addrSel)
      AS_LINE:   busAddr = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      AS_VICTIM: busAddr = {victimTagQ, qIdx, {OFF_W{1'b0}}};
      default:   busAddr = addrQ;
    endcase
  end

endmodule

// File: rtl/dcp_control.sv
module dcp_control
  import dcp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqMode,
  input  logic [2:0] reqClass,
  input  logic       noAlloc,
  input  logic       snpValid,
  input  logic       snpWrite,
  input  logic       snpEnable,
  input  lineState_e reqState,
  input  logic       reqMatch,
  input  lineState_e snpState,
  input  logic       snpMatch,
  input  logic       busDone,
  output dpCtrl_t    ctrl,
  output logic       reqReady,
  output logic       snpReady,
  output logic       busValid,
  output logic [1:0] busCmd,
  output logic       respValid,
  output logic       respHit,
  output logic       snpConflict
);

  ctlState_e state, stateNext;
  busCmd_e   singleCmdQ, singleCmdNext;
  logic      fillDirtyQ, fillDirtyNext;
  logic      hitQ, hitNext;
  logic      doneNow, doneHit, conflictNext;

  logic idle, snpTake, accept;
  logic inhibited, bypass, present, hit, allocOk, copyback, doFill;

  assign idle     = (state == ST_IDLE);
  assign snpTake  = idle && snpValid && snpEnable;
  assign reqReady = idle && !snpTake;
  assign snpReady = idle;
  assign accept   = reqValid && reqReady;

  assign inhibited = reqMode[1] || (reqClass == AC_LOCKED);
  assign bypass    = inhibited || (reqClass == AC_WALK);
  assign present   = (reqState != LS_INV) && reqMatch;
  assign hit       = !bypass && present;
  assign allocOk   = !noAlloc && (reqClass != AC_EXCEPT) && (reqClass != AC_BLOCK);
  assign copyback  = (reqMode == PM_CB);
  assign doFill    = !bypass && !present && allocOk && (!reqWrite || copyback);

  assign busValid = !idle;

  always_comb begin
    unique case (state)
      ST_WBACK: busCmd = BC_WBACK;
      ST_FILL:  busCmd = BC_FILL;
      ST_SINGLE: busCmd = singleCmdQ;
      default:  busCmd = BC_READ;
    endcase
  end

  always_comb begin
    ctrl          = '0;
    ctrl.addrSel  = AS_FULL;
    stateNext     = state;
    singleCmdNext = singleCmdQ;
    fillDirtyNext = fillDirtyQ;
    hitNext       = hitQ;
    doneNow       = 1'b0;
    doneHit       = 1'b0;
    conflictNext  = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (snpTake) begin
          if (snpWrite && snpMatch) begin
            if (snpState == LS_VALID) ctrl.snpInv = 1'b1;
            if (snpState == LS_DIRTY) conflictNext = 1'b1;
          end
        end else if (accept) begin
          ctrl.latch = 1'b1;
          hitNext    = hit;
          if (hit) begin
            if (!reqWrite) begin
              doneNow = 1'b1;
              doneHit = 1'b1;
            end else if (reqClass == AC_BLOCK) begin
              ctrl.hitInv   = 1'b1;
              singleCmdNext = BC_WRITE;
              stateNext     = ST_SINGLE;
            end else if (copyback) begin
              ctrl.hitDirty = 1'b1;
              doneNow       = 1'b1;
              doneHit       = 1'b1;
            end else begin
              singleCmdNext = BC_WRITE;
              stateNext     = ST_SINGLE;
            end
          end else if (doFill) begin
            fillDirtyNext = reqWrite;
            stateNext     = (reqState == LS_DIRTY) ? ST_WBACK : ST_FILL;
          end else begin
            singleCmdNext = reqWrite ? BC_WRITE : BC_READ;
            stateNext     = ST_SINGLE;
          end
        end
      end
      ST_WBACK: begin
        ctrl.addrSel = AS_VICTIM;
        if (busDone) begin
          ctrl.victimInv = 1'b1;
          stateNext      = ST_FILL;
        end
      end
      ST_FILL: begin
        ctrl.addrSel = AS_LINE;
        if (busDone) begin
          ctrl.fillWrite = 1'b1;
          ctrl.fillDirty = fillDirtyQ;
          doneNow        = 1'b1;
          doneHit        = 1'b0;
          stateNext      = ST_IDLE;
        end
      end
      default: begin
        if (busDone) begin
          doneNow   = 1'b1;
          doneHit   = hitQ;
          stateNext = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      singleCmdQ  <= BC_READ;
      fillDirtyQ  <= 1'b0;
      hitQ        <= 1'b0;
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      snpConflict <= 1'b0;
    end else begin
      state       <= stateNext;
      singleCmdQ  <= singleCmdNext;
      fillDirtyQ  <= fillDirtyNext;
      hitQ        <= hitNext;
      respValid   <= doneNow;
      respHit     <= doneNow && doneHit;
      snpConflict <= conflictNext;
    end
  end

endmodule

// File: rtl/dcache_policy_ctrl.sv
module dcache_policy_ctrl
  import dcp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 reqValid,
  output logic                                 reqReady,
  input  logic                                 reqWrite,
  input  logic [ADDR_W-1:0]                    reqAddr,
  input  logic [1:0]                           reqMode,
  input  logic [2:0]                           reqClass,
  input  logic                                 noAlloc,
  output logic                                 respValid,
  output logic                                 respHit,
  input  logic                                 snpValid,
  output logic                                 snpReady,
  input  logic                                 snpWrite,
  input  logic                                 snpEnable,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] snpLine,
  output logic                                 snpConflict,
  output logic                                 busValid,
  output logic [1:0]                           busCmd,
  output logic [ADDR_W-1:0]                    busAddr,
  input  logic                                 busDone
);

  dpCtrl_t    ctrl;
  lineState_e reqState, snpState;
  logic       reqMatch, snpMatch;

  dcp_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqAddr(reqAddr), .snpLine(snpLine),
    .reqState(reqState), .reqMatch(reqMatch),
    .snpState(snpState), .snpMatch(snpMatch),
    .busAddr(busAddr)
  );

  dcp_control uControl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqMode(reqMode),
    .reqClass(reqClass), .noAlloc(noAlloc),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpEnable(snpEnable),
    .reqState(reqState), .reqMatch(reqMatch),
    .snpState(snpState), .snpMatch(snpMatch),
    .busDone(busDone), .ctrl(ctrl),
    .reqReady(reqReady), .snpReady(snpReady),
    .busValid(busValid), .busCmd(busCmd),
    .respValid(respValid), .respHit(respHit),
    .snpConflict(snpConflict)
  );

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [2:0]        reqClass,
  input logic              respValid,
  input logic              snpValid,
  input logic              snpReady,
  input logic              snpWrite,
  input logic              snpEnable,
  input logic              snpConflict,
  input logic              busValid,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busDone
);

  p_hold_cmd_r14: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busDone |=> busValid && $stable(busCmd) && $stable(busAddr));

  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busCmd == 2'd3 && busDone |=> busValid && busCmd == 2'd2);

  p_walk_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqClass == 3'd3 |=> busValid && !busCmd[1]);

  p_locked_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqClass == 3'd4 |=>
      busValid && !busCmd[1] && busCmd[0] == $past(reqWrite));

  p_conflict_src_r12: assert property (@(posedge clk) disable iff (!rstN)
    snpConflict |-> $past(snpValid && snpEnable && snpWrite && snpReady));

  p_busy_blocks_r13: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady && !snpReady);

  p_snoop_first_r13: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && snpEnable && snpReady |-> !reqReady);

  p_resp_src_r13: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past((reqValid && reqReady) || (busValid && busDone)));

endmodule

bind dcache_policy_ctrl dcp_checker #(.ADDR_W(ADDR_W)) uChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqClass(reqClass), .respValid(respValid),
  .snpValid(snpValid), .snpReady(snpReady), .snpWrite(snpWrite),
  .snpEnable(snpEnable), .snpConflict(snpConflict), .busValid(busValid),
  .busCmd(busCmd), .busAddr(busAddr), .busDone(busDone)
);

// File: tb/dcache_policy_ctrl_test.sv
module dcache_policy_ctrl_test;

  localparam int ADDR_W = 32;
  localparam int NVEC   = 30;
  localparam logic [2:0] NONE = 3'd7;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0, noAlloc = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqMode = 2'd0;
  logic [2:0]        reqClass = 3'd0;
  logic              snpValid = 1'b0, snpWrite = 1'b0, snpEnable = 1'b0;
  logic [ADDR_W-5:0] snpLine = '0;
  logic              busDone = 1'b0;
  logic              reqReady, respValid, respHit, snpReady, snpConflict, busValid;
  logic [1:0]        busCmd;
  logic [ADDR_W-1:0] busAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [2:0]        seenCmd [2];
  logic [ADDR_W-1:0] seenAddr [2];
  logic              seenHit;

  dcache_policy_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqMode(reqMode),
    .reqClass(reqClass), .noAlloc(noAlloc), .respValid(respValid),
    .respHit(respHit), .snpValid(snpValid), .snpReady(snpReady),
    .snpWrite(snpWrite), .snpEnable(snpEnable), .snpLine(snpLine),
    .snpConflict(snpConflict), .busValid(busValid), .busCmd(busCmd),
    .busAddr(busAddr), .busDone(busDone)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one request, answering each bus command; stall delays each busDone
  task automatic access(input logic wr, input logic [31:0] addr, input logic [1:0] mode,
                        input logic [2:0] cls, input logic na, input int stall);
    int   n = 0;
    int   left = 0;
    logic holding = 1'b0;
    logic [1:0] holdCmd = 2'd0;
    seenCmd[0] = NONE; seenCmd[1] = NONE; seenAddr[0] = '0; seenAddr[1] = '0;
    seenHit = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqMode = mode;
    reqClass = cls; noAlloc = na;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (busValid) begin
        if (!holding) begin
          if (n < 2) begin seenCmd[n] = {1'b0, busCmd}; seenAddr[n] = busAddr; end
          n++;
          holdCmd = busCmd;
          left = stall;
          holding = 1'b1;
        end else begin
          check("R14 held cmd", {30'd0, busCmd}, {30'd0, holdCmd});
        end
        if (left > 0) begin busDone = 1'b0; left--; end
        else begin busDone = 1'b1; holding = 1'b0; end
      end else begin
        busDone = 1'b0;
        if (respValid) begin
          seenHit = respHit;
          break;
        end
      end
    end
  endtask

  task automatic snoop(input logic wr, input logic en, input logic [ADDR_W-5:0] line,
                       input logic expConflict, input string tag);
    @(negedge clk);
    snpValid = 1'b1; snpWrite = wr; snpEnable = en; snpLine = line;
    @(negedge clk);
    snpValid = 1'b0;
    check(tag, {31'd0, snpConflict}, {31'd0, expConflict});
  endtask

  // {write, addr16, mode2, class3, noAlloc, cmd1, cmd2, hit, req4}
  // cmd: 0 read, 1 write, 2 fill, 3 writeback, 7 none
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0,16'h0100,2'd1,3'd0,1'b0,3'd2,3'd7,1'b0,4'd1},   // R1 read miss fills
    {1'b0,16'h0100,2'd1,3'd0,1'b0,3'd7,3'd7,1'b1,4'd1},   // R1 now hits
    {1'b1,16'h0100,2'd1,3'd0,1'b0,3'd7,3'd7,1'b1,4'd5},   // R5 copyback write hit
    {1'b0,16'h0200,2'd1,3'd0,1'b0,3'd3,3'd2,1'b0,4'd6},   // R6 dirty victim
    {1'b1,16'h0310,2'd0,3'd0,1'b0,3'd1,3'd7,1'b0,4'd4},   // R4 wt write miss
    {1'b0,16'h0310,2'd0,3'd0,1'b0,3'd2,3'd7,1'b0,4'd1},   // R1 wt read miss fills
    {1'b1,16'h0310,2'd0,3'd0,1'b0,3'd1,3'd7,1'b1,4'd5},   // R5 wt write hit
    {1'b0,16'h0420,2'd1,3'd0,1'b1,3'd0,3'd7,1'b0,4'd2},   // R2 read no-alloc
    {1'b0,16'h0420,2'd1,3'd0,1'b0,3'd2,3'd7,1'b0,4'd2},   // R2 still absent
    {1'b1,16'h0530,2'd1,3'd0,1'b1,3'd1,3'd7,1'b0,4'd2},   // R2 write no-alloc
    {1'b1,16'h0530,2'd1,3'd0,1'b0,3'd2,3'd7,1'b0,4'd3},   // R3 cb write miss fills
    {1'b0,16'h0530,2'd1,3'd0,1'b0,3'd7,3'd7,1'b1,4'd3},   // R3 present
    {1'b0,16'h0640,2'd1,3'd1,1'b0,3'd0,3'd7,1'b0,4'd7},   // R7 exception miss
    {1'b0,16'h0640,2'd1,3'd0,1'b0,3'd2,3'd7,1'b0,4'd7},   // R7 not allocated
    {1'b1,16'h0640,2'd1,3'd1,1'b0,3'd7,3'd7,1'b1,4'd7},   // R7 exception cb hit
    {1'b0,16'h0740,2'd1,3'd0,1'b0,3'd3,3'd2,1'b0,4'd7},   // R7 became dirty
    {1'b1,16'h0850,2'd1,3'd2,1'b0,3'd1,3'd7,1'b0,4'd8},   // R8 block write miss
    {1'b0,16'h0850,2'd1,3'd2,1'b0,3'd0,3'd7,1'b0,4'd8},   // R8 block read miss
    {1'b0,16'h0850,2'd1,3'd0,1'b0,3'd2,3'd7,1'b0,4'd8},   // R8 not allocated
    {1'b0,16'h0850,2'd1,3'd2,1'b0,3'd7,3'd7,1'b1,4'd8},   // R8 block read hit
    {1'b1,16'h0850,2'd1,3'd2,1'b0,3'd1,3'd7,1'b1,4'd8},   // R8 block write hit
    {1'b0,16'h0850,2'd1,3'd0,1'b0,3'd2,3'd7,1'b0,4'd8},   // R8 was invalidated
    {1'b0,16'h0850,2'd1,3'd3,1'b0,3'd0,3'd7,1'b0,4'd9},   // R9 walk read bypass
    {1'b1,16'h0850,2'd1,3'd3,1'b0,3'd1,3'd7,1'b0,4'd9},   // R9 walk write bypass
    {1'b0,16'h0850,2'd1,3'd0,1'b0,3'd7,3'd7,1'b1,4'd9},   // R9 line kept
    {1'b0,16'h0950,2'd1,3'd0,1'b0,3'd2,3'd7,1'b0,4'd9},   // R9 not dirtied
    {1'b1,16'h0950,2'd1,3'd4,1'b0,3'd1,3'd7,1'b0,4'd10},  // R10 locked write
    {1'b0,16'h0950,2'd1,3'd4,1'b0,3'd0,3'd7,1'b0,4'd10},  // R10 locked read
    {1'b0,16'h0A50,2'd1,3'd0,1'b0,3'd2,3'd7,1'b0,4'd10},  // R10 not dirtied
    {1'b0,16'h0A50,2'd2,3'd0,1'b0,3'd0,3'd7,1'b0,4'd10}   // R10 inhibited page
  };

  initial begin
    // reset state (R13)
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R13 reset reqReady", {31'd0, reqReady}, 32'd1);
    check("R13 reset snpReady", {31'd0, snpReady}, 32'd1);
    check("R13 reset busValid", {31'd0, busValid}, 32'd0);
    check("R13 reset respValid", {31'd0, respValid}, 32'd0);
    check("R13 reset snpConflict", {31'd0, snpConflict}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [33:0] e;
      e = VEC[v];
      access(e[33], {16'd0, e[32:17]}, e[16:15], e[14:12], e[11], 0);
      check($sformatf("R%0d vec%0d cmd1", e[3:0], v), {29'd0, seenCmd[0]}, {29'd0, e[10:8]});
      check($sformatf("R%0d vec%0d cmd2", e[3:0], v), {29'd0, seenCmd[1]}, {29'd0, e[7:5]});
      check($sformatf("R%0d vec%0d hit", e[3:0], v), {31'd0, seenHit}, {31'd0, e[4]});
    end

    // R11 snoops: disabled write, enabled read, enabled write on valid line 0x310
    snoop(1'b1, 1'b0, 28'h31, 1'b0, "R11 disabled snoop flag");
    access(1'b0, 32'h310, 2'd0, 3'd0, 1'b0, 0);
    check("R11 disabled snoop keeps line", {31'd0, seenHit}, 32'd1);
    snoop(1'b0, 1'b1, 28'h31, 1'b0, "R11 snoop read flag");
    access(1'b0, 32'h310, 2'd0, 3'd0, 1'b0, 0);
    check("R11 snoop read keeps line", {31'd0, seenHit}, 32'd1);
    snoop(1'b1, 1'b1, 28'h31, 1'b0, "R11 snoop write flag");
    access(1'b0, 32'h310, 2'd0, 3'd0, 1'b0, 0);
    check("R11 snoop write invalidated", {29'd0, seenCmd[0]}, 32'd2);

    // R12 snoop write on dirty line 0x530
    snoop(1'b1, 1'b1, 28'h53, 1'b1, "R12 conflict raised");
    @(negedge clk);
    check("R12 conflict one cycle", {31'd0, snpConflict}, 32'd0);
    snoop(1'b1, 1'b1, 28'h153, 1'b0, "R11 snoop miss no flag");
    access(1'b0, 32'h530, 2'd1, 3'd0, 1'b0, 0);
    check("R12 dirty line unchanged", {31'd0, seenHit}, 32'd1);
    access(1'b0, 32'h1530, 2'd1, 3'd0, 1'b0, 0);
    check("R12 still dirty on evict", {29'd0, seenCmd[0]}, 32'd3);

    // R6 addresses, R4 full address
    access(1'b1, 32'hB64, 2'd1, 3'd0, 1'b0, 0);
    check("R3 fill addr aligned", seenAddr[0], 32'hB60);
    access(1'b0, 32'hC68, 2'd1, 3'd0, 1'b0, 0);
    check("R6 writeback cmd", {29'd0, seenCmd[0]}, 32'd3);
    check("R6 victim addr", seenAddr[0], 32'hB60);
    check("R6 fill addr", seenAddr[1], 32'hC60);
    access(1'b1, 32'hD74, 2'd0, 3'd0, 1'b0, 0);
    check("R4 single write addr", seenAddr[0], 32'hD74);

    // R14 stalled busDone
    access(1'b0, 32'hE80, 2'd1, 3'd0, 1'b0, 3);
    check("R14 stalled fill", {29'd0, seenCmd[0]}, 32'd2);
    check("R14 stalled resp", {31'd0, seenHit}, 32'd0);

    // R13 snoop priority over a waiting request
    @(negedge clk);
    snpValid = 1'b1; snpWrite = 1'b0; snpEnable = 1'b1; snpLine = 28'hE8;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 32'hE80; reqMode = 2'd1; reqClass = 3'd0;
    #1;
    check("R13 snoop blocks request", {31'd0, reqReady}, 32'd0);
    @(negedge clk);
    snpValid = 1'b0; reqValid = 1'b0;
    #1;
    check("R13 ready after snoop", {31'd0, reqReady}, 32'd1);
    check("R13 no response for unaccepted", {31'd0, respValid}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule